// File: doc/BRIEF.md
# Event-Detecting General-Purpose I/O Bank

This block is a bank of 32 general-purpose I/O pins behind a simple memory-mapped register bus. Each pin has a direction bit, an output data bit and a sampled input bit. Single-cycle set and clear aliases let software change single bits of the output data and of the three enable masks without a read-modify-write. Every pin input passes through a two-flop synchronizer and then through an optional debounce filter. The debounce window is counted in ticks of a divided reference clock.

Each pin can raise an event on four conditions: input low, input high, rising edge and falling edge. Any mix of the four may be enabled, and the event is their OR. Events latch into two independent status registers. Each status register is ANDed with its own enable mask to form one interrupt line. A third mask, qualified by a global wake-enable bit, produces a wakeup output. A self-clearing soft-reset bit returns every register to its reset value and reports completion in a status bit. A module-off bit freezes input sampling and event capture, while bus access keeps working.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset, direction (0x34) reads 0xFFFFFFFF (all inputs) and `pin_oe_n` equals it. Data out, both status registers, all enables and detects, config (0x10) and control (0x30) read 0. Status (0x14) bit 0 reads 1. `irq_a`, `irq_b` and `wake` are 0.
- R2: Direction bit 1 makes the pin an input and bit 0 an output. `pin_oe_n` mirrors register 0x34, and `pin_out` mirrors data out (0x3C).
- R3: The write-only aliases change only the bits written as 1. 0x90/0x94 clear/set data out, 0x60/0x64 clear/set enable 1 (0x1C), 0x70/0x74 clear/set enable 2 (0x2C), and 0x80/0x84 clear/set wake enable (0x20). Reads of alias addresses return 0.
- R4: Data in (0x38) returns the pin inputs after a two-flop synchronizer. An undebounced change is visible within 6 cycles.
- R5: Per-pin detect masks are low level (0x40), high level (0x44), rising (0x48) and falling (0x4C). An enabled condition sets the pin's bit in both status 1 (0x18) and status 2 (0x28). `irq_a` is the OR of status 1 AND enable 1, and `irq_b` is the OR of status 2 AND enable 2.
- R6: Writing 1 to a status bit clears it in that cycle. Writing 0 has no effect. A level condition that still holds sets the bit again on the next cycle.
- R7: `wake` is the OR over pins of (event AND wake enable), gated by config bit 2. With config bit 2 at 0, `wake` is 0.
- R8: For a pin whose debounce bit (0x50) is set, an input change passes to data in only after it stays stable for (window+1) reference ticks, where the window is the 8-bit field at 0x54. Shorter pulses are dropped. Pins whose debounce bit is clear are not filtered.
- R9: Writing config with bit 1 set resets every register to its reset value. Status bit 0 reads 0 during the reset cycle and 1 afterwards. Config bit 1 reads back 0.
- R10: While control bit 0 is 1, inputs are not sampled and no new events latch, but register reads and writes still work. Clearing the bit resumes sampling.
- R11: Config bits 4:3, 2 and 0 and control bits 2:0 are stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| pin_in | input | 32 | Raw pin inputs |
| pin_out | output | 32 | Output data to pad drivers |
| pin_oe_n | output | 32 | Direction, 1 = input (driver off) |
| irq_a | output | 1 | Interrupt line 1 |
| irq_b | output | 1 | Interrupt line 2 |
| wake | output | 1 | Wakeup request |

## Verification
The bench builds the bank with a reference divider of 4 clocks per tick and a debounce window of 2. One filter window is then about a dozen cycles. This lets a 5-cycle glitch be shown as rejected and a held level as accepted within 40 cycles, next to an unfiltered pin that catches the same glitch as a rising edge. The short divider also keeps the soft-reset and module-off sequences well inside the run.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int NPIN = 32;
  localparam int DBW  = 8;

  localparam logic [7:0] A_CFG      = 8'h10;
  localparam logic [7:0] A_STAT     = 8'h14;
  localparam logic [7:0] A_ST1      = 8'h18;
  localparam logic [7:0] A_EN1      = 8'h1C;
  localparam logic [7:0] A_WK       = 8'h20;
  localparam logic [7:0] A_ST2      = 8'h28;
  localparam logic [7:0] A_EN2      = 8'h2C;
  localparam logic [7:0] A_CTRL     = 8'h30;
  localparam logic [7:0] A_DIR      = 8'h34;
  localparam logic [7:0] A_DIN      = 8'h38;
  localparam logic [7:0] A_DOUT     = 8'h3C;
  localparam logic [7:0] A_LOW      = 8'h40;
  localparam logic [7:0] A_HIGH     = 8'h44;
  localparam logic [7:0] A_RISE     = 8'h48;
  localparam logic [7:0] A_FALL     = 8'h4C;
  localparam logic [7:0] A_DEBEN    = 8'h50;
  localparam logic [7:0] A_DEBWIN   = 8'h54;
  localparam logic [7:0] A_EN1_CLR  = 8'h60;
  localparam logic [7:0] A_EN1_SET  = 8'h64;
  localparam logic [7:0] A_EN2_CLR  = 8'h70;
  localparam logic [7:0] A_EN2_SET  = 8'h74;
  localparam logic [7:0] A_WK_CLR   = 8'h80;
  localparam logic [7:0] A_WK_SET   = 8'h84;
  localparam logic [7:0] A_DOUT_CLR = 8'h90;
  localparam logic [7:0] A_DOUT_SET = 8'h94;

  typedef struct packed {
    logic [NPIN-1:0] dir;
    logic [NPIN-1:0] dout;
    logic [NPIN-1:0] en1;
    logic [NPIN-1:0] en2;
    logic [NPIN-1:0] wk;
    logic [NPIN-1:0] low;
    logic [NPIN-1:0] high;
    logic [NPIN-1:0] rise;
    logic [NPIN-1:0] fall;
    logic [NPIN-1:0] deben;
    logic [DBW-1:0]  debwin;
    logic [4:0]      cfg;
    logic [2:0]      ctrl;
  } bank_regs_t;

  localparam bank_regs_t REGS_RST = '{dir: '1, default: '0};

  function automatic logic [NPIN-1:0] pin_events(
    input logic [NPIN-1:0] lo, hi, ri, fa, cur, prv);
    return (lo & ~cur) | (hi & cur) | (ri & cur & ~prv) | (fa & ~cur & prv);
  endfunction

  function automatic logic [NPIN-1:0] mask_update(
    input logic [NPIN-1:0] cur, setm, clrm);
    return (cur | setm) & ~clrm;
  endfunction
endpackage

// File: rtl/gpio_evt_tick.sv
module gpio_evt_tick #(
  parameter int DIV = 3875
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gpio_evt_filter.sv
module gpio_evt_filter #(
  parameter int N  = 32,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold,
  input  logic          tick,
  input  logic [N-1:0]  pin_i,
  input  logic [N-1:0]  deb_en,
  input  logic [TW-1:0] win,
  output logic [N-1:0]  filt_o
);
  logic [N-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else if (clr) begin
      s1 <= '0;
      s2 <= '0;
    end else if (!hold) begin
      s1 <= pin_i;
      s2 <= s1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [TW-1:0] cnt;
    logic          f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        f_q <= 1'b0;
      end else if (clr) begin
        cnt <= '0;
        f_q <= 1'b0;
      end else if (!hold) begin
        if (!deb_en[g]) begin
          f_q <= s2[g];
          cnt <= '0;
        end else if (s2[g] == f_q) begin
          cnt <= '0;
        end else if (tick) begin
          if (cnt >= win) begin
            f_q <= s2[g];
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
    assign filt_o[g] = f_q;
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            hold,
  input  logic [NPIN-1:0] filt,
  input  logic [NPIN-1:0] lo,
  input  logic [NPIN-1:0] hi,
  input  logic [NPIN-1:0] ri,
  input  logic [NPIN-1:0] fa,
  output logic [NPIN-1:0] evt
);
  logic [NPIN-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev <= '0;
    else if (clr)     prev <= '0;
    else if (!hold)   prev <= filt;
  end

  assign evt = hold ? '0 : pin_events(lo, hi, ri, fa, filt, prev);
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_evt_pkg::*;
#(
  parameter int TICK_DIV = 3875
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  input  logic        bus_re,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe_n,
  output logic        irq_a,
  output logic        irq_b,
  output logic        wake
);
  bank_regs_t      r, n;
  logic [NPIN-1:0] st1, st2, st1_n, st2_n;
  logic [NPIN-1:0] filt, evt;
  logic            srst_pend, rst_done, tick;

  // named internal events for the checker
  wire             mod_off  = r.ctrl[0];
  wire             wake_ena = r.cfg[2];
  wire [NPIN-1:0]  dout_q   = r.dout;
  wire             srst_req = bus_we && (bus_addr == A_CFG) && bus_wdata[1];

  gpio_evt_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(srst_pend), .tick(tick));

  gpio_evt_filter #(.N(NPIN), .TW(DBW)) u_filt (
    .clk(clk), .rst_n(rst_n), .clr(srst_pend), .hold(mod_off), .tick(tick),
    .pin_i(pin_in), .deb_en(r.deben), .win(r.debwin), .filt_o(filt));

  gpio_evt_detect u_det (
    .clk(clk), .rst_n(rst_n), .clr(srst_pend), .hold(mod_off), .filt(filt),
    .lo(r.low), .hi(r.high), .ri(r.rise), .fa(r.fall), .evt(evt));

  always_comb begin
    n = r;
    st1_n = st1 | evt;
    st2_n = st2 | evt;
    if (bus_we) begin
      case (bus_addr)
        A_CFG:      n.cfg    = {bus_wdata[4:2], 1'b0, bus_wdata[0]};
        A_CTRL:     n.ctrl   = bus_wdata[2:0];
        A_DIR:      n.dir    = bus_wdata;
        A_DOUT:     n.dout   = bus_wdata;
        A_EN1:      n.en1    = bus_wdata;
        A_EN2:      n.en2    = bus_wdata;
        A_WK:       n.wk     = bus_wdata;
        A_LOW:      n.low    = bus_wdata;
        A_HIGH:     n.high   = bus_wdata;
        A_RISE:     n.rise   = bus_wdata;
        A_FALL:     n.fall   = bus_wdata;
        A_DEBEN:    n.deben  = bus_wdata;
        A_DEBWIN:   n.debwin = bus_wdata[DBW-1:0];
        A_ST1:      st1_n    = st1_n & ~bus_wdata;
        A_ST2:      st2_n    = st2_n & ~bus_wdata;
        A_EN1_CLR:  n.en1    = mask_update(r.en1, '0, bus_wdata);
        A_EN1_SET:  n.en1    = mask_update(r.en1, bus_wdata, '0);
        A_EN2_CLR:  n.en2    = mask_update(r.en2, '0, bus_wdata);
        A_EN2_SET:  n.en2    = mask_update(r.en2, bus_wdata, '0);
        A_WK_CLR:   n.wk     = mask_update(r.wk, '0, bus_wdata);
        A_WK_SET:   n.wk     = mask_update(r.wk, bus_wdata, '0);
        A_DOUT_CLR: n.dout   = mask_update(r.dout, '0, bus_wdata);
        A_DOUT_SET: n.dout   = mask_update(r.dout, bus_wdata, '0);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r         <= REGS_RST;
      st1       <= '0;
      st2       <= '0;
      srst_pend <= 1'b0;
      rst_done  <= 1'b0;
    end else if (srst_pend) begin
      r         <= REGS_RST;
      st1       <= '0;
      st2       <= '0;
      srst_pend <= 1'b0;
      rst_done  <= 1'b0;
    end else begin
      r         <= n;
      st1       <= st1_n;
      st2       <= st2_n;
      srst_pend <= srst_req;
      rst_done  <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        A_CFG:    bus_rdata = {27'd0, r.cfg};
        A_STAT:   bus_rdata = {31'd0, rst_done};
        A_ST1:    bus_rdata = st1;
        A_EN1:    bus_rdata = r.en1;
        A_WK:     bus_rdata = r.wk;
        A_ST2:    bus_rdata = st2;
        A_EN2:    bus_rdata = r.en2;
        A_CTRL:   bus_rdata = {29'd0, r.ctrl};
        A_DIR:    bus_rdata = r.dir;
        A_DIN:    bus_rdata = filt;
        A_DOUT:   bus_rdata = r.dout;
        A_LOW:    bus_rdata = r.low;
        A_HIGH:   bus_rdata = r.high;
        A_RISE:   bus_rdata = r.rise;
        A_FALL:   bus_rdata = r.fall;
        A_DEBEN:  bus_rdata = r.deben;
        A_DEBWIN: bus_rdata = {{(32-DBW){1'b0}}, r.debwin};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pin_out  = r.dout;
  assign pin_oe_n = r.dir;
  assign irq_a    = |(st1 & r.en1);
  assign irq_b    = |(st2 & r.en2);
  assign wake     = wake_ena & |(evt & r.wk);
endmodule

// File: rtl/gpio_evt_checker.sv
module gpio_evt_checker
  import gpio_evt_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      bus_addr,
  input logic            bus_we,
  input logic [31:0]     bus_wdata,
  input logic [NPIN-1:0] st1,
  input logic [NPIN-1:0] st2,
  input logic            mod_off,
  input logic            srst_pend,
  input logic            rst_done,
  input logic            wake,
  input logic            wake_ena,
  input logic [NPIN-1:0] dout_q
);
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_ST1) |=> ((st1 & $past(bus_wdata)) == '0)); // R6

  AST_OFF_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    mod_off |=> (((st1 & ~$past(st1)) == '0) && ((st2 & ~$past(st2)) == '0))); // R10

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pend |=> (!rst_done && dout_q == '0 && st1 == '0)); // R9

  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_ena |-> !wake); // R7

  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DOUT_SET && !srst_pend)
      |=> ((dout_q & $past(bus_wdata)) == $past(bus_wdata))); // R3
endmodule

bind gpio_evt_bank gpio_evt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .st1(st1), .st2(st2), .mod_off(mod_off),
  .srst_pend(srst_pend), .rst_done(rst_done), .wake(wake),
  .wake_ena(wake_ena), .dout_q(dout_q));

// File: tb/gpio_evt_bank_tb.sv
module gpio_evt_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe_n;
  logic        irq_a, irq_b, wake;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  gpio_evt_bank #(.TICK_DIV(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe_n(pin_oe_n),
    .irq_a(irq_a), .irq_b(irq_b), .wake(wake));

  // monitor: pops expected read data when the bus reads
  always @(negedge clk) begin
    if (bus_re) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: addr %h actual %h expected %h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_re = 1'b0;
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 oe_n", pin_oe_n, 32'hFFFF_FFFF);
    chk("R1 irq", {29'd0, irq_a, irq_b, wake}, 32'd0);
    rd(8'h34, 32'hFFFF_FFFF, "R1");
    rd(8'h3C, 32'h0, "R1");
    rd(8'h14, 32'h1, "R1");
    rd(8'h18, 32'h0, "R1");
    rd(8'h10, 32'h0, "R1");
    // R2 direction and output
    wr(8'h34, 32'hFFFF_0000);
    wr(8'h3C, 32'h0000_A5A5);
    chk("R2 oe_n", pin_oe_n, 32'hFFFF_0000);
    chk("R2 out", pin_out, 32'h0000_A5A5);
    // R3 aliases
    wr(8'h94, 32'h0000_0F00);
    wr(8'h90, 32'h0000_00A5);
    rd(8'h3C, 32'h0000_AF00, "R3");
    chk("R3 out", pin_out, 32'h0000_AF00);
    rd(8'h94, 32'h0, "R3");
    wr(8'h64, 32'h3);
    wr(8'h60, 32'h1);
    rd(8'h1C, 32'h2, "R3");
    wr(8'h74, 32'h10);
    rd(8'h2C, 32'h10, "R3");
    wr(8'h84, 32'h40);
    wr(8'h80, 32'h0);
    rd(8'h20, 32'h40, "R3");
    wr(8'h1C, 32'h0);
    wr(8'h2C, 32'h0);
    // R4 synchronized input
    pin_in = 32'h1234_0000;
    cyc(6);
    rd(8'h38, 32'h1234_0000, "R4");
    pin_in = 32'h0;
    cyc(6);
    rd(8'h18, 32'h0, "R4");
    // R5 edge detection and two lines
    wr(8'h48, 32'h1);
    wr(8'h1C, 32'h1);
    pin_in = 32'h1;
    cyc(6);
    rd(8'h18, 32'h1, "R5");
    rd(8'h28, 32'h1, "R5");
    chk("R5 irq_a", {31'd0, irq_a}, 32'd1);
    chk("R5 irq_b", {31'd0, irq_b}, 32'd0);
    wr(8'h2C, 32'h1);
    chk("R5 irq_b en", {31'd0, irq_b}, 32'd1);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    pin_in = 32'h0;
    cyc(6);
    rd(8'h18, 32'h0, "R5");
    wr(8'h4C, 32'h1);
    pin_in = 32'h1;
    cyc(6);
    rd(8'h18, 32'h1, "R5");
    wr(8'h18, 32'h1);
    pin_in = 32'h0;
    cyc(6);
    rd(8'h18, 32'h1, "R5");
    wr(8'h18, 32'h0);
    rd(8'h18, 32'h1, "R6");
    wr(8'h18, 32'h1);
    wr(8'h48, 32'h0);
    wr(8'h4C, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
    // R6 level re-set after clear
    wr(8'h44, 32'h4);
    wr(8'h1C, 32'h4);
    pin_in = 32'h4;
    cyc(6);
    chk("R6 irq_a", {31'd0, irq_a}, 32'd1);
    wr(8'h18, 32'h4);
    chk("R6 cleared", {31'd0, irq_a}, 32'd0);
    cyc(1);
    chk("R6 reset", {31'd0, irq_a}, 32'd1);
    rd(8'h18, 32'h4, "R6");
    pin_in = 32'h0;
    cyc(6);
    wr(8'h18, 32'h4);
    rd(8'h18, 32'h0, "R6");
    wr(8'h44, 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
    // R7 wakeup from low level on pin 6
    wr(8'h10, 32'h04);
    wr(8'h40, 32'h40);
    cyc(2);
    chk("R7 wake", {31'd0, wake}, 32'd1);
    wr(8'h10, 32'h00);
    chk("R7 gated", {31'd0, wake}, 32'd0);
    // R11 config and control fields
    wr(8'h10, 32'h1D);
    rd(8'h10, 32'h1D, "R11");
    wr(8'h30, 32'h6);
    rd(8'h30, 32'h6, "R11");
    wr(8'h30, 32'h0);
    wr(8'h40, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    // R8 debounce: pin 3 filtered, pin 4 not
    wr(8'h54, 32'h2);
    wr(8'h50, 32'h8);
    wr(8'h48, 32'h18);
    rd(8'h54, 32'h2, "R8");
    pin_in = 32'h18;
    cyc(5);
    pin_in = 32'h0;
    cyc(40);
    rd(8'h38, 32'h0, "R8");
    rd(8'h18, 32'h10, "R8");
    wr(8'h18, 32'hFFFF_FFFF);
    pin_in = 32'h8;
    cyc(40);
    rd(8'h38, 32'h8, "R8");
    rd(8'h18, 32'h8, "R8");
    wr(8'h48, 32'h0);
    pin_in = 32'h0;
    cyc(40);
    rd(8'h38, 32'h0, "R8");
    // R10 module off
    wr(8'h48, 32'h20);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h30, 32'h1);
    pin_in = 32'h20;
    cyc(10);
    rd(8'h38, 32'h0, "R10");
    rd(8'h18, 32'h0, "R10");
    wr(8'h2C, 32'h55);
    rd(8'h2C, 32'h55, "R10");
    wr(8'h30, 32'h0);
    cyc(6);
    rd(8'h38, 32'h20, "R10");
    rd(8'h18, 32'h20, "R10");
    // R9 soft reset
    wr(8'h10, 32'h02);
    rd(8'h14, 32'h0, "R9");
    rd(8'h14, 32'h1, "R9");
    rd(8'h10, 32'h0, "R9");
    rd(8'h34, 32'hFFFF_FFFF, "R9");
    rd(8'h3C, 32'h0, "R9");
    rd(8'h18, 32'h0, "R9");
    rd(8'h2C, 32'h0, "R9");
    rd(8'h48, 32'h0, "R9");
    chk("R9 out", pin_out, 32'h0);
    cyc(2);
    chk("R9 queue empty", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule